// File: doc/BRIEF.md
# Host-to-Microcontroller Command Mailbox

This block is a register-mapped mailbox through which a host processor hands commands to an embedded display microcontroller. The host fills a 32-bit parameter register and a 32-bit command word, then rings a doorbell. The command word packs one byte per field: an opcode, a pipe id, a dimming level and a spare byte. The microcontroller side sees the pending command, performs it, and pulses an acknowledge to clear the doorbell. The doorbell lets only one command be pending at a time. The host polls a busy output, or the doorbell bit in the control register, before it posts the next command.

The block decodes three opcodes. When a pipe-select names pipe 255, it raises an immediate-disable strobe. It keeps the controller id from the most recent pipe-select that was posted. When a backlight command is pending and that controller id is 0, the parameter presented to the consumer is forced to 0. A write that arrives while a command is pending is dropped and sets a sticky error flag.

Top module: `cmd_mailbox`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: doorbell, error flag, command word, parameter register, tracked pipe id, busy and request.
- R2: While the doorbell is clear, a host write to address 1 (command word) or address 2 (parameter) is stored. A read of that address returns the stored value in the cycle after the write.
- R3: While the doorbell is clear, a host write to address 0 with bit 0 set posts the command. From the cycle after the write, busy, request and read bit 0 of address 0 are all 1.
- R4: While a command is pending, the consumer sees the following, held stable until the acknowledge: opcode from command bits 7:0, pipe id from bits 15:8, level from bits 23:16, spare byte from bits 31:24, and the parameter.
- R5: While the doorbell is set, a host write to address 1 or 2, or a post, is ignored. It sets the error flag (address 0 bit 1 and the error output), which stays set until reset.
- R6: An acknowledge while a command is pending clears the doorbell at the next clock edge. A post in the following cycle is accepted.
- R7: Immediate-disable is 1 only while a pipe-select command (opcode 0x66) with pipe id 0xFF is pending.
- R8: For a pending backlight command (opcode 0x67), the presented parameter is 0 if the tracked pipe id is 0, and the parameter register otherwise.
- R9: Posting a pipe-select loads the tracked pipe id from command bits 15:8. Posting a level-set (0x65) or any other opcode leaves it unchanged. For every opcode other than 0x67, the presented parameter equals the parameter register.
- R10: An acknowledge while the doorbell is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 2 | Host register address (0 control, 1 command, 2 parameter) |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read data of the addressed register |
| hst_busy | output | 1 | Doorbell set, command pending |
| hst_err | output | 1 | Sticky error flag for dropped writes |
| mcu_req | output | 1 | Command pending toward the consumer |
| mcu_opcode | output | 8 | Opcode byte |
| mcu_pipe | output | 8 | Pipe id byte |
| mcu_level | output | 8 | Level byte |
| mcu_spare | output | 8 | Spare byte |
| mcu_param | output | 32 | Parameter after ramp forcing |
| mcu_imm_disable | output | 1 | Pipe-select with pipe 255 pending |
| mcu_ack | input | 1 | Consumer acknowledge |

## Verification
Each register write takes effect at the clock edge that samples it. Stored values, the doorbell, the error flag and the decoded consumer outputs are therefore due one cycle after the stimulus, and read data follows the address combinationally. The bench drives every input on the falling edge and holds it across one rising edge. It then checks at the next falling edge, so every check falls one full edge after its cause. The back-to-back case posts on the falling edge that directly follows the acknowledging edge, which proves that one cycle of turnaround is enough.

// File: rtl/mbx_pkg.sv
// Package: shared constants and register map for the command mailbox.
// Assumes byte-packed command words of four fields.
package mbx_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OPC_LEVEL = 8'h65;
    localparam logic [7:0] OPC_PIPE  = 8'h66;
    localparam logic [7:0] OPC_BLSET = 8'h67;
    localparam logic [7:0] PIPE_KILL = 8'hFF;

    localparam int CTRL_POST_BIT = 0;
    localparam int CTRL_ERR_BIT  = 1;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CMD  = 2'd1,
        REG_DATA = 2'd2,
        REG_RSVD = 2'd3
    } mbx_reg_e;
endpackage

// File: rtl/mbx_host_regs.sv
// Host register file: command word, parameter register and sticky error flag.
// Assumes the doorbell state arrives as 'busy'. Writes are gated while busy.
module mbx_host_regs
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CMD_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [DATA_W-1:0] data_q,
    output logic              err_q,
    output logic              post
);
    logic wr_ctrl, wr_cmd, wr_data, blocked;

    // Decode the addressed register for the current write.
    always_comb begin
        wr_ctrl = wr && (mbx_reg_e'(addr) == REG_CTRL);
        wr_cmd  = wr && (mbx_reg_e'(addr) == REG_CMD);
        wr_data = wr && (mbx_reg_e'(addr) == REG_DATA);
        post    = wr_ctrl && wdata[CTRL_POST_BIT] && !busy;
        blocked = busy && (wr_cmd || wr_data || (wr_ctrl && wdata[CTRL_POST_BIT]));
    end

    // Store command and parameter writes while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else if (!busy) begin
            if (wr_cmd)  cmd_q  <= wdata[CMD_W-1:0];
            if (wr_data) data_q <= wdata;
        end
    end

    // Latch the error flag on any write dropped while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (blocked) err_q <= 1'b1;
    end
endmodule

// File: rtl/mbx_doorbell.sv
// Doorbell flag: set by an accepted post, cleared by consumer acknowledge.
// Assumes 'post' is asserted only while the flag is clear.
module mbx_doorbell (
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic ack,
    output logic bell_q
);
    // Hold one pending command at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)           bell_q <= 1'b0;
        else if (post)        bell_q <= 1'b1;
        else if (ack && bell_q) bell_q <= 1'b0;
    end
endmodule

// File: rtl/mbx_decode.sv
// Command decoder: splits the command word into bytes and tracks the
// selected pipe. Applies the controller-0 ramp forcing and flags immediate
// disable. Assumes the command word is frozen while the doorbell is set.
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CMD_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bell,
    input  logic                        post,
    input  logic [CMD_BYTES*BYTE_W-1:0] cmd,
    input  logic [DATA_W-1:0]           data,
    output logic [CMD_BYTES*BYTE_W-1:0] fields,
    output logic [DATA_W-1:0]           param,
    output logic                        imm_disable
);
    logic [BYTE_W-1:0] cmd_byte [CMD_BYTES];
    logic [BYTE_W-1:0] sel_pipe_q;

    genvar gi;
    generate
        for (gi = 0; gi < CMD_BYTES; gi++) begin : g_bytes
            assign cmd_byte[gi] = cmd[gi*BYTE_W +: BYTE_W];
            assign fields[gi*BYTE_W +: BYTE_W] = cmd_byte[gi];
        end
    endgenerate

    // Remember the controller named by the last posted pipe-select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_pipe_q <= '0;
        else if (post && cmd_byte[0] == OPC_PIPE)
            sel_pipe_q <= cmd_byte[1];
    end

    // Present the parameter and the immediate-disable strobe.
    always_comb begin
        if (cmd_byte[0] == OPC_BLSET && sel_pipe_q == '0)
            param = '0;
        else
            param = data;
        imm_disable = bell && cmd_byte[0] == OPC_PIPE && cmd_byte[1] == PIPE_KILL;
    end
endmodule

// File: rtl/cmd_mailbox.sv
// Top: host-to-microcontroller command mailbox. Ties the register file,
// doorbell and decoder together and muxes host read data.
// Assumes a single synchronous clock domain for host and consumer.
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_wr,
    input  logic [1:0]        hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_busy,
    output logic              hst_err,
    output logic              mcu_req,
    output logic [7:0]        mcu_opcode,
    output logic [7:0]        mcu_pipe,
    output logic [7:0]        mcu_level,
    output logic [7:0]        mcu_spare,
    output logic [DATA_W-1:0] mcu_param,
    output logic              mcu_imm_disable,
    input  logic              mcu_ack
);
    localparam int CMD_BYTES = 4;
    localparam int CMD_W     = CMD_BYTES * BYTE_W;

    logic [CMD_W-1:0]  cmd_q, fields;
    logic [DATA_W-1:0] data_q;
    logic              err_q, post, bell_q;

    mbx_host_regs #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(hst_wr), .addr(hst_addr),
        .wdata(hst_wdata), .busy(bell_q), .cmd_q(cmd_q), .data_q(data_q),
        .err_q(err_q), .post(post)
    );

    mbx_doorbell u_bell (
        .clk(clk), .rst_n(rst_n), .post(post), .ack(mcu_ack), .bell_q(bell_q)
    );

    mbx_decode #(.DATA_W(DATA_W), .CMD_BYTES(CMD_BYTES)) u_dec (
        .clk(clk), .rst_n(rst_n), .bell(bell_q), .post(post), .cmd(cmd_q),
        .data(data_q), .fields(fields), .param(mcu_param),
        .imm_disable(mcu_imm_disable)
    );

    // Drive status and consumer byte outputs.
    always_comb begin
        hst_busy   = bell_q;
        hst_err    = err_q;
        mcu_req    = bell_q;
        mcu_opcode = fields[7:0];
        mcu_pipe   = fields[15:8];
        mcu_level  = fields[23:16];
        mcu_spare  = fields[31:24];
    end

    // Return the addressed register to the host.
    always_comb begin
        hst_rdata = '0;
        case (mbx_reg_e'(hst_addr))
            REG_CTRL: begin
                hst_rdata[CTRL_POST_BIT] = bell_q;
                hst_rdata[CTRL_ERR_BIT]  = err_q;
            end
            REG_CMD:  hst_rdata[CMD_W-1:0] = cmd_q;
            REG_DATA: hst_rdata = data_q;
            default:  hst_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_checker.sv
// Checker: temporal properties of the mailbox ports, bound to the top.
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_wr,
    input logic [1:0]        hst_addr,
    input logic [DATA_W-1:0] hst_wdata,
    input logic              hst_err,
    input logic              mcu_req,
    input logic [7:0]        mcu_opcode,
    input logic [7:0]        mcu_pipe,
    input logic [DATA_W-1:0] mcu_param,
    input logic              mcu_imm_disable,
    input logic              mcu_ack
);
    AST_POST_SETS_BELL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mcu_req && hst_wr && hst_addr == 2'd0 && hst_wdata[0]) |=> mcu_req); // R3
    AST_ACK_CLEARS_BELL: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_req && mcu_ack) |=> !mcu_req); // R6
    AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_req && $past(mcu_req)) |-> ($stable(mcu_opcode) && $stable(mcu_param))); // R4
    AST_ERR_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_req && hst_wr && (hst_addr == 2'd1 || hst_addr == 2'd2)) |=> hst_err); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hst_err |=> hst_err); // R5
    AST_IMM_ONLY_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        mcu_imm_disable |-> (mcu_req && mcu_opcode == OPC_PIPE && mcu_pipe == PIPE_KILL)); // R7
    AST_IDLE_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mcu_req && mcu_ack && !hst_wr) |=> !mcu_req); // R10
endmodule

bind cmd_mailbox mbx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_err(hst_err), .mcu_req(mcu_req),
    .mcu_opcode(mcu_opcode), .mcu_pipe(mcu_pipe), .mcu_param(mcu_param),
    .mcu_imm_disable(mcu_imm_disable), .mcu_ack(mcu_ack)
);

// File: tb/test_cmd_mailbox.sv
// Directed bench for the command mailbox; one task per scenario.
module test_cmd_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr = 1'b0;
    logic [1:0]  hst_addr = 2'd0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        hst_busy, hst_err, mcu_req, mcu_imm_disable;
    logic [7:0]  mcu_opcode, mcu_pipe, mcu_level, mcu_spare;
    logic [31:0] mcu_param;
    logic        mcu_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cmd_mailbox i_cmd_mailbox (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_busy(hst_busy),
        .hst_err(hst_err), .mcu_req(mcu_req), .mcu_opcode(mcu_opcode),
        .mcu_pipe(mcu_pipe), .mcu_level(mcu_level), .mcu_spare(mcu_spare),
        .mcu_param(mcu_param), .mcu_imm_disable(mcu_imm_disable),
        .mcu_ack(mcu_ack)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One host write, held across one rising edge; returns at the falling edge.
    task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
        hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr = 1'b0; hst_wdata = '0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
        hst_addr = a;
        #1 d = hst_rdata;
    endtask

    task automatic pulse_ack();
        mcu_ack = 1'b1;
        @(negedge clk);
        mcu_ack = 1'b0;
    endtask

    task automatic post_cmd(input logic [31:0] cmd, input logic [31:0] data);
        host_wr(2'd2, data);
        host_wr(2'd1, cmd);
        host_wr(2'd0, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        host_rd(2'd0, r); chk("R1", "ctrl", r, 32'h0);
        host_rd(2'd1, r); chk("R1", "cmd", r, 32'h0);
        host_rd(2'd2, r); chk("R1", "data", r, 32'h0);
        chk("R1", "busy/req/err", {hst_busy, mcu_req, hst_err}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] r;
        host_wr(2'd1, 32'hA5C3_1E77);
        host_rd(2'd1, r); chk("R2", "cmd readback", r, 32'hA5C3_1E77);
        host_wr(2'd2, 32'h1234_5678);
        host_rd(2'd2, r); chk("R2", "data readback", r, 32'h1234_5678);
        chk("R2", "no post", mcu_req, 1'b0);
    endtask

    task automatic t_level();
        logic [31:0] r;
        post_cmd(32'h9C2A_0065, 32'hDEAD_0001);
        chk("R3", "busy", hst_busy, 1'b1);
        chk("R3", "req", mcu_req, 1'b1);
        host_rd(2'd0, r); chk("R3", "ctrl bit0", r[0], 1'b1);
        chk("R4", "opcode", mcu_opcode, 8'h65);
        chk("R4", "level", mcu_level, 8'h2A);
        chk("R4", "spare", mcu_spare, 8'h9C);
        chk("R9", "level param", mcu_param, 32'hDEAD_0001);
        @(negedge clk);
        chk("R4", "opcode held", mcu_opcode, 8'h65);
        pulse_ack();
        chk("R6", "req cleared", mcu_req, 1'b0);
    endtask

    task automatic t_ramp_ctrl0();
        post_cmd(32'h0000_0066, 32'h0000_FFFF);
        chk("R9", "pipe param", mcu_param, 32'h0000_FFFF);
        chk("R7", "no kill pipe0", mcu_imm_disable, 1'b0);
        pulse_ack();
        post_cmd(32'h0000_0067, 32'h0000_0030);
        chk("R8", "ramp forced", mcu_param, 32'h0);
        pulse_ack();
    endtask

    task automatic t_ramp_ctrl2();
        post_cmd(32'h0000_0266, 32'h0000_FFFF);
        pulse_ack();
        post_cmd(32'h0000_0067, 32'h0000_0030);
        chk("R8", "ramp kept", mcu_param, 32'h30);
        pulse_ack();
        post_cmd(32'h0011_0065, 32'h0);
        pulse_ack();
        post_cmd(32'h0000_0067, 32'h0000_0044);
        chk("R9", "pipe unchanged by level", mcu_param, 32'h44);
        pulse_ack();
    endtask

    task automatic t_kill();
        post_cmd(32'h0000_FF66, 32'h0000_FFFF);
        chk("R7", "kill strobe", mcu_imm_disable, 1'b1);
        chk("R4", "pipe byte", mcu_pipe, 8'hFF);
        pulse_ack();
        chk("R7", "kill drops", mcu_imm_disable, 1'b0);
        post_cmd(32'h0000_0366, 32'h0000_FFFF);
        pulse_ack();
    endtask

    task automatic t_idle_ack();
        logic [31:0] r;
        pulse_ack();
        chk("R10", "idle ack req", mcu_req, 1'b0);
        host_rd(2'd0, r); chk("R10", "idle ack ctrl", r, 32'h0);
    endtask

    task automatic t_back_to_back();
        post_cmd(32'h0000_0567, 32'h0000_0077);
        pulse_ack();
        host_wr(2'd0, 32'h1);
        chk("R6", "repost next cycle", mcu_req, 1'b1);
        pulse_ack();
    endtask

    task automatic t_busy_write();
        logic [31:0] r;
        post_cmd(32'h0000_0167, 32'h0000_0055);
        host_wr(2'd1, 32'hFFFF_FFFF);
        host_rd(2'd1, r); chk("R5", "cmd kept", r, 32'h0000_0167);
        chk("R5", "err set", hst_err, 1'b1);
        host_wr(2'd2, 32'hFFFF_FFFF);
        host_rd(2'd2, r); chk("R5", "data kept", r, 32'h0000_0055);
        host_rd(2'd0, r); chk("R5", "ctrl err bit", r[1:0], 2'b11);
        pulse_ack();
        chk("R5", "err sticky", hst_err, 1'b1);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_level();
        t_ramp_ctrl0();
        t_ramp_ctrl2();
        t_kill();
        t_idle_ack();
        t_back_to_back();
        t_busy_write();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        #(8 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule